// File: doc/BRIEF.md
# Manchester Receiver with Carrier Sense

This block takes a Manchester-coded serial line, already synchronised to a fast local clock and sampled eight times per bit cell. It looks for qualifying activity and raises carrier sense. It then recovers bit timing from the mid-cell transitions and delivers NRZ data, one bit at a time, each with a one-cycle strobe. When the line has been quiet for a fixed number of samples after the last transition, it drops carrier sense and returns to hunting.

Each transition re-anchors the bit timer, so the sampling phase follows a line whose half-cells drift by a sample either way. Two qualification rules are available. The twisted-pair rule waits for an alternating run of decoded bits. The attachment-unit rule accepts a single decoded bit. The bits used to qualify are discarded and never strobed out. A status output mirrors the carrier-sense level.

Top module: `mrx_carrier_rx`

## Requirements
- R1: While rst_ni is low, and after its release with an idle line, crs_o, strobe_o and status_o are 0.
- R2: With mode_i = 0 (twisted pair), crs_o goes high in the cycle that follows the capture of the fourth consecutive decoded bit of an alternating run (1010 or 0101). A bit cell is 8 samples. A bit of 1 is sent low then high, and a bit of 0 is sent high then low. The bit value is the direction of the mid-cell transition.
- R3: With mode_i = 1 (attachment unit), crs_o goes high in the cycle that follows the capture of the first decoded bit, including a single isolated transition.
- R4: strobe_o is never high before crs_o has risen. Qualifying bits are dropped. A twisted-pair burst of fewer than four decoded bits leaves crs_o low.
- R5: While crs_o is high, each later bit cell produces exactly one one-cycle strobe_o, with data_o equal to that cell's bit, in line order.
- R6: Data decodes correctly when each half-cell lasts 3, 4 or 5 samples, because every accepted mid-cell transition re-anchors the sampling phase. Transitions arriving less than 6 samples after the last anchor are taken as cell boundaries.
- R7: crs_o stays high without a break from qualification until the end of the frame.
- R8: crs_o falls between 1.3 and 2.3 bit times after the last rising transition of the line. The design releases 14 samples after the last transition.
- R9: In twisted-pair mode, a frame whose first transition is a cell boundary still qualifies on the mid-cell transitions of its first four bits. An early transition restarts the qualification run.
- R10: status_o equals crs_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, 8 per bit cell |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised line sample |
| mode_i | input | 1 | 0: twisted-pair qualification, 1: attachment-unit qualification |
| crs_o | output | 1 | Carrier sense |
| data_o | output | 1 | Decoded NRZ bit, valid with strobe_o |
| strobe_o | output | 1 | One-cycle bit-valid strobe |
| status_o | output | 1 | Carrier-sense status bit |

## Verification
The hardest case to reach from the ports is a twisted-pair frame whose first transition falls on a cell boundary. In that case the hunting logic has to discard an anchor it has already taken and restart its alternating run on the true mid-cell edge. The bench produces this case by starting a preamble with the bit whose first half differs from the idle level. It then checks that carrier rises exactly on the fourth mid-cell edge and that the payload still decodes. Phase tracking is driven by payloads whose half-cells are randomly stretched or shrunk by one sample. Release timing is measured from the last rising edge the bench itself drove.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic {
    ST_HUNT    = 1'b0,
    ST_CARRIER = 1'b1
  } mrx_state_e;

  typedef enum logic {
    LINK_PAIR = 1'b0,
    LINK_UNIT = 1'b1
  } mrx_link_e;

  typedef struct packed {
    logic anchor;   // transition accepted as mid-cell
    logic restart;  // early transition re-anchored while hunting
    logic timeout;  // quiet limit reached
    logic bit_val;  // direction of anchoring transition
  } mrx_evt_t;

endpackage

// File: rtl/mrx_edge_det.sv
module mrx_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o,
  output logic rise_o
);

  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_i;
  end

  assign edge_o = line_i ^ line_q;
  assign rise_o = line_i & ~line_q;

endmodule

// File: rtl/mrx_bit_timer.sv
module mrx_bit_timer
  import mrx_pkg::*;
#(
  parameter int unsigned CELL_SAMPLES = 8,
  parameter int unsigned QUIET_LIMIT  = 14
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     edge_i,
  input  logic     rise_i,
  input  logic     resync_en_i,
  output mrx_evt_t evt_o
);

  localparam int unsigned MID_MIN = (CELL_SAMPLES * 3) / 4;
  localparam int unsigned PH_TOP  = 2 * CELL_SAMPLES;
  localparam int unsigned PW      = $clog2(PH_TOP + 1);
  localparam int unsigned QW      = $clog2(QUIET_LIMIT + 1);
  localparam logic [PW-1:0] EARLY_LIM = PW'(MID_MIN - 1);
  localparam logic [PW-1:0] PH_MAX    = PW'(PH_TOP);
  localparam logic [QW-1:0] Q_LIM     = QW'(QUIET_LIMIT - 1);

  logic          track_q;
  logic [PW-1:0] phase_q;
  logic [QW-1:0] quiet_q;
  logic          early;
  logic          anchor;
  logic          timeout;

  assign early   = phase_q < EARLY_LIM;
  assign anchor  = edge_i & (~track_q | ~early | resync_en_i);
  assign timeout = track_q & ~edge_i & (quiet_q == Q_LIM);

  assign evt_o.anchor  = anchor;
  assign evt_o.restart = anchor & track_q & early;
  assign evt_o.timeout = timeout;
  assign evt_o.bit_val = rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      track_q <= 1'b0;
      phase_q <= '0;
      quiet_q <= '0;
    end else begin
      if (anchor)       track_q <= 1'b1;
      else if (timeout) track_q <= 1'b0;

      if (anchor)                phase_q <= '0;
      else if (phase_q != PH_MAX) phase_q <= phase_q + 1'b1;

      if (edge_i || timeout)             quiet_q <= '0;
      else if (track_q && quiet_q != Q_LIM) quiet_q <= quiet_q + 1'b1;
    end
  end

  // R8
  quiet_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(track_q) |-> $past(quiet_q) == Q_LIM);

endmodule

// File: rtl/mrx_carrier_fsm.sv
module mrx_carrier_fsm
  import mrx_pkg::*;
#(
  parameter int unsigned PAIR_QUAL = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_i,
  input  mrx_evt_t evt_i,
  output logic     crs_o,
  output logic     data_o,
  output logic     strobe_o,
  output logic     resync_en_o
);

  localparam int unsigned HW = (PAIR_QUAL < 2) ? 2 : PAIR_QUAL;
  localparam int unsigned CW = $clog2(HW + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(HW);

  mrx_state_e    state_q;
  logic [HW-1:0] hist_q, hist_n;
  logic [CW-1:0] cnt_q, cnt_n, need;
  logic [HW-2:0] alt;
  logic          alt_ok;
  logic          qualified;
  logic          strobe_q, data_q;

  assign hist_n = {hist_q[HW-2:0], evt_i.bit_val};

  for (genvar i = 0; i < HW - 1; i++) begin : g_alt
    assign alt[i] = hist_n[i] ^ hist_n[i+1];
  end
  assign alt_ok = &alt;

  assign need  = (mode_i == LINK_UNIT) ? CW'(1) : CNT_TOP;
  assign cnt_n = evt_i.restart     ? CW'(1) :
                 (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
  assign qualified = evt_i.anchor && (cnt_n >= need) &&
                     ((mode_i == LINK_UNIT) || alt_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      hist_q   <= '0;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      data_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      case (state_q)
        ST_HUNT: begin
          if (evt_i.timeout) begin
            cnt_q <= '0;
          end else if (evt_i.anchor) begin
            if (qualified) begin
              state_q <= ST_CARRIER;
              cnt_q   <= '0;
            end else begin
              cnt_q  <= cnt_n;
              hist_q <= hist_n;
            end
          end
        end
        ST_CARRIER: begin
          if (evt_i.timeout) begin
            state_q <= ST_HUNT;
          end else if (evt_i.anchor) begin
            strobe_q <= 1'b1;
            data_q   <= evt_i.bit_val;
          end
        end
      endcase
    end
  end

  assign crs_o       = (state_q == ST_CARRIER);
  assign resync_en_o = (state_q == ST_HUNT);
  assign strobe_o    = strobe_q;
  assign data_o      = data_q;

  // R4
  strobe_needs_crs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> crs_o);
  // R4
  no_strobe_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crs_o) |-> !strobe_o);
  // R2
  rise_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crs_o) |-> $past(evt_i.anchor));
  // R7
  fall_on_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(crs_o) |-> $past(evt_i.timeout));

endmodule

// File: rtl/mrx_carrier_rx.sv
module mrx_carrier_rx
  import mrx_pkg::*;
#(
  parameter int unsigned CELL_SAMPLES = 8,
  parameter int unsigned QUIET_LIMIT  = 14,
  parameter int unsigned PAIR_QUAL    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic mode_i,
  output logic crs_o,
  output logic data_o,
  output logic strobe_o,
  output logic status_o
);

  logic     edge_w, rise_w, resync_w;
  mrx_evt_t evt_w;

  mrx_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .edge_o (edge_w),
    .rise_o (rise_w)
  );

  mrx_bit_timer #(
    .CELL_SAMPLES (CELL_SAMPLES),
    .QUIET_LIMIT  (QUIET_LIMIT)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (edge_w),
    .rise_i      (rise_w),
    .resync_en_i (resync_w),
    .evt_o       (evt_w)
  );

  mrx_carrier_fsm #(
    .PAIR_QUAL (PAIR_QUAL)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .evt_i       (evt_w),
    .crs_o       (crs_o),
    .data_o      (data_o),
    .strobe_o    (strobe_o),
    .resync_en_o (resync_w)
  );

  assign status_o = crs_o;

  // R10
  status_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == crs_o);

endmodule

// File: tb/mrx_carrier_rx_tb.sv
`timescale 1ns/1ps
module mrx_carrier_rx_tb_top;

  localparam int CELL = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line = 1'b0;
  logic mode = 1'b0;
  logic crs, data, strobe, status;

  always #2.5 clk = ~clk;

  mrx_carrier_rx dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .line_i   (line),
    .mode_i   (mode),
    .crs_o    (crs),
    .data_o   (data),
    .strobe_o (strobe),
    .status_o (status)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int samp = 0;
  int last_rise = 0;

  int rise_at, fall_at, n_rise, n_fall, rx_n, pre_strobe, stat_bad;
  bit crs_prev;
  bit rx_bits [256];

  function automatic int exp_qual(bit m);
    return m ? 1 : 4;
  endfunction

  function automatic bit in_window(int d);
    return (d * 10 >= 13 * CELL) && (d * 10 <= 23 * CELL);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    rise_at = -1; fall_at = -1; n_rise = 0; n_fall = 0;
    rx_n = 0; pre_strobe = 0; stat_bad = 0; crs_prev = crs;
  endtask

  always begin
    @(posedge clk);
    #1;
    if (rst_ni) begin
      if (status !== crs) stat_bad++;
      if (strobe) begin
        if (n_rise == 0) pre_strobe++;
        else if (rx_n < 256) begin rx_bits[rx_n] = data; rx_n++; end
      end
      if (crs && !crs_prev) begin n_rise++; if (rise_at < 0) rise_at = samp; end
      if (!crs && crs_prev) begin n_fall++; if (fall_at < 0) fall_at = samp; end
      crs_prev = crs;
    end
  end

  task automatic put(bit v);
    @(negedge clk);
    samp++;
    if (v && !line) last_rise = samp;
    line = v;
  endtask

  task automatic send_bit(bit b, int h1, int h2, output int mid);
    repeat (h1) put(!b);
    put(b);
    mid = samp;
    repeat (h2 - 1) put(b);
  endtask

  task automatic run_frame(bit m, int npay, bit jit, bit misal, string tag);
    bit bits [80];
    int mids [80];
    int n, q, bad, first_bad;
    bit b0;
    mode = m;
    mon_clear();
    n = 8 + npay + 1;
    b0 = misal ? line : !line;
    for (int i = 0; i < 8; i++) bits[i] = b0 ^ i[0];
    for (int i = 8; i < n - 1; i++) bits[i] = 1'($urandom_range(0, 1));
    bits[n-1] = 1'b1;
    for (int i = 0; i < n; i++) begin
      int h1, h2;
      h1 = 4; h2 = 4;
      if (jit && i >= 8) begin
        h1 = 3 + int'($urandom_range(0, 2));
        h2 = 3 + int'($urandom_range(0, 2));
      end
      send_bit(bits[i], h1, h2, mids[i]);
    end
    repeat (30) put(line);
    q = exp_qual(m);
    chk(rise_at == mids[q-1], $sformatf("%s %s crs rise sample", tag, m ? "R3" : "R2"),
        rise_at, mids[q-1]);
    chk(pre_strobe == 0, $sformatf("%s R4 strobes before carrier", tag), pre_strobe, 0);
    chk(rx_n == n - q, $sformatf("%s R5 strobe count", tag), rx_n, n - q);
    bad = 0; first_bad = -1;
    for (int i = 0; i < rx_n && i < n - q; i++)
      if (rx_bits[i] != bits[i+q]) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, $sformatf("%s %s data mismatches (first at %0d)", tag,
        jit ? "R6" : "R5", first_bad), bad, 0);
    chk(n_rise == 1 && n_fall == 1, $sformatf("%s R7 crs edges rise+fall", tag),
        n_rise + n_fall, 2);
    chk(in_window(fall_at - last_rise), $sformatf("%s R8 release delay", tag),
        fall_at - last_rise, 14);
    chk(stat_bad == 0, $sformatf("%s R10 status mismatch", tag), stat_bad, 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int e;
    void'($urandom(32'h5eed_0c1a));
    repeat (3) @(negedge clk);
    chk(crs == 1'b0, "R1 crs in reset", int'(crs), 0);
    chk(strobe == 1'b0, "R1 strobe in reset", int'(strobe), 0);
    chk(status == 1'b0, "R1 R10 status in reset", int'(status), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(crs == 1'b0 && strobe == 1'b0, "R1 idle after reset", int'(crs) + int'(strobe), 0);

    // R3: single isolated rising transition in attachment-unit mode
    mode = 1'b1;
    mon_clear();
    put(1'b1);
    e = samp;
    repeat (30) put(1'b1);
    chk(rise_at == e, "R3 single bit qualifies", rise_at, e);
    chk(rx_n == 0 && pre_strobe == 0, "R4 qualifying bit discarded", rx_n + pre_strobe, 0);
    chk(in_window(fall_at - e), "R8 release after single edge", fall_at - e, 14);

    run_frame(1'b0, 24, 1'b0, 1'b0, "pair clean");
    run_frame(1'b1, 24, 1'b0, 1'b0, "unit clean");
    for (int k = 0; k < 4; k++) run_frame(1'b0, 16 + k * 12, 1'b1, 1'b0, "pair jitter");
    for (int k = 0; k < 3; k++) run_frame(1'b1, 20 + k * 10, 1'b1, 1'b0, "unit jitter");
    run_frame(1'b0, 20, 1'b0, 1'b1, "R9 misaligned start");
    run_frame(1'b0, 30, 1'b1, 1'b1, "R9 misaligned jitter");

    // R4: twisted-pair burst of three bits must not qualify
    mode = 1'b0;
    mon_clear();
    begin
      int mid;
      bit b;
      b = !line;
      for (int i = 0; i < 3; i++) begin
        send_bit(b, 4, 4, mid);
        b = !b;
      end
    end
    repeat (30) put(line);
    chk(n_rise == 0, "R4 short pair burst keeps crs low", n_rise, 0);
    chk(rx_n + pre_strobe == 0, "R4 short pair burst no strobes", rx_n + pre_strobe, 0);

    run_frame(1'b0, 40, 1'b1, 1'b0, "pair after burst");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule